// File: doc/BRIEF.md
# Fractional-Rate Pixel Strobe Generator

This block sits in the fast link clock domain of a video transmitter. Its output marks the cycles that carry one parallel group of pixels. Each group holds eight pixels by default. When the link clock runs faster than the pixel-group rate, only some cycles can carry a group. The pixel-group rate is the pixel rate divided by the pixels per clock. The block accepts a ratio N/M, where N is the number of carrying cycles and M is the period in cycles. It then marks exactly N cycles in every M consecutive cycles and spreads them as evenly as possible, so that the link bandwidth is used at a steady rate. For example, a ratio of 33/50 marks 33 cycles in every 50.

An error accumulator produces the spacing. On each cycle the block adds N to the accumulator. Whenever the sum reaches M, the block subtracts M and marks that cycle. Pixel groups arrive through a dual-clock buffer that shows its head word while it is not empty. The block reads that buffer only on marked cycles when the buffer holds data. It registers the group together with a valid flag. If a marked cycle finds the buffer empty, a sticky underflow flag is raised. N and M are captured during reset and again on a load pulse. A ratio with M equal to zero, or with N greater than M, is rejected: the error flag rises and the block marks no cycles.

Top module: `pix_strobe_gen`

## Requirements
- R1: With a valid ratio N/M, every run of M consecutive cycles counted from the first cycle after a load, or after reset release, contains exactly N cycles with `slot` high.
- R2: With cycle k=0 being the first cycle after a load or after reset release, `slot` is high in cycle k exactly when floor((k+1)·N/M) > floor(k·N/M). As a result, the gaps between successive strobes differ by at most one cycle.
- R3: When N equals M and M is non-zero, `slot` is high on every cycle.
- R4: When N is zero and M is non-zero, `slot` stays low and `cfg_err` stays low.
- R5: When M is zero or N is greater than M, `cfg_err` is high, `slot` and `buf_rd` stay low, and `pix_valid` stays low.
- R6: `buf_rd` is high in the same cycle exactly when `slot` is high and `buf_empty` is low.
- R7: `pix_valid` is high in the cycle after a cycle with `buf_rd` high. In that cycle `pix_data` equals the `buf_data` value seen during the read. In all other cases `pix_valid` is low and `pix_data` holds its value.
- R8: `underflow` rises in the cycle after a cycle with `slot` high and `buf_empty` high. Once high it stays high until reset; a new load does not clear it.
- R9: While `cfg_load` is low and reset is released, changes on `cfg_num` and `cfg_den` have no effect on the strobe pattern.
- R10: During reset (`rst_n` low, sampled on the clock) `pix_valid`, `underflow`, `pix_data` and `slot` are all zero. The ratio present on `cfg_num` and `cfg_den` during reset is the one in force after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures the ratio |
| cfg_load | input | 1 | Capture a new ratio and restart the pattern |
| cfg_num | input | RW | Carrying cycles per period (N) |
| cfg_den | input | RW | Period length in cycles (M) |
| buf_empty | input | 1 | Buffer has no group available |
| buf_data | input | PIX_PER_GRP·PIX_W | Head group of the buffer |
| buf_rd | output | 1 | Pop the head group from the buffer |
| slot | output | 1 | This cycle carries a pixel group |
| pix_valid | output | 1 | Registered group qualifier |
| pix_data | output | PIX_PER_GRP·PIX_W | Registered pixel group |
| cfg_err | output | 1 | Captured ratio is invalid |
| underflow | output | 1 | Sticky: a strobe found the buffer empty |

## Verification
The assertions assume that `buf_empty` and `buf_data` are stable around the clock edge. They also assume that the buffer shows its head word without a read being issued first. A load may arrive on any cycle, and the assertions make no assumption about when. The stimulus changes every input only at the falling edge. It drives random garbage on the ratio inputs whenever no load is issued, which exercises R9. The random ratios always keep N no greater than M, except in the deliberately rejected directed cases.

// File: rtl/pix_strobe_gen.sv
module pix_strobe_gen #(
  parameter int RW          = 8,
  parameter int PIX_PER_GRP = 8,
  parameter int PIX_W       = 10,
  localparam int DW         = PIX_PER_GRP * PIX_W,
  localparam int AW         = RW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [RW-1:0] cfg_num,
  input  logic [RW-1:0] cfg_den,
  input  logic          buf_empty,
  input  logic [DW-1:0] buf_data,
  output logic          buf_rd,
  output logic          slot,
  output logic          pix_valid,
  output logic [DW-1:0] pix_data,
  output logic          cfg_err,
  output logic          underflow
);

  logic [RW-1:0] num_q, den_q;
  logic          ok_q;
  logic [AW-1:0] acc_q, sum;
  logic          take, cfg_good;

  assign take     = !rst_n || cfg_load;
  assign cfg_good = (cfg_den != '0) && (cfg_num <= cfg_den);
  assign sum      = acc_q + AW'(num_q);
  assign slot     = rst_n && ok_q && (sum >= AW'(den_q));
  assign buf_rd   = slot && !buf_empty;
  assign cfg_err  = !ok_q;

  always_ff @(posedge clk) begin
    if (take) begin
      num_q <= cfg_num;
      den_q <= cfg_den;
      ok_q  <= cfg_good;
      acc_q <= '0;
    end else if (slot) begin
      acc_q <= sum - AW'(den_q);
    end else if (ok_q) begin
      acc_q <= sum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      underflow <= 1'b0;
    end else begin
      pix_valid <= buf_rd;
      if (buf_rd) pix_data <= buf_data;
      if (slot && buf_empty) underflow <= 1'b1;
    end
  end

  AST_ACC_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) !cfg_err |-> acc_q < AW'(den_q));  // R2
  AST_FULL_RATE:    assert property (@(posedge clk) disable iff (!rst_n) (!cfg_err && num_q == den_q) |-> slot); // R3
  AST_BAD_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> !slot && !buf_rd);   // R5
  AST_RD_GATED:     assert property (@(posedge clk) disable iff (!rst_n) buf_empty |-> !buf_rd);          // R6
  AST_VALID_AFTER:  assert property (@(posedge clk) disable iff (!rst_n) buf_rd |=> pix_valid);           // R7
  AST_DATA_HELD:    assert property (@(posedge clk) disable iff (!rst_n) !buf_rd |=> !pix_valid && $stable(pix_data)); // R7
  AST_UF_RISE:      assert property (@(posedge clk) disable iff (!rst_n) (slot && buf_empty) |=> underflow); // R8
  AST_UF_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) underflow |=> underflow);        // R8

endmodule

// File: tb/pix_strobe_gen_bench.sv
`timescale 1ns/1ps
module pix_strobe_gen_bench;
  localparam int RW = 8;
  localparam int DW = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [RW-1:0] cfg_num = '0, cfg_den = '0;
  logic buf_empty = 1'b1;
  logic [DW-1:0] buf_data = '0;
  logic buf_rd, slot, pix_valid, cfg_err, underflow;
  logic [DW-1:0] pix_data;

  pix_strobe_gen #(.RW(RW), .PIX_PER_GRP(8), .PIX_W(10)) u_pix_strobe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_num(cfg_num), .cfg_den(cfg_den),
    .buf_empty(buf_empty), .buf_data(buf_data), .buf_rd(buf_rd), .slot(slot),
    .pix_valid(pix_valid), .pix_data(pix_data), .cfg_err(cfg_err), .underflow(underflow));

  always #5 clk = ~clk;

  int checks = 0, errs = 0;
  int k = 0, cn = 0, cm = 1;
  bit cok = 1'b0, uf_m = 1'b0, prd = 1'b0;
  logic [DW-1:0] pdat = '0;
  bit hist [0:1023];

  function automatic bit exp_slot(int kk, int n, int m, bit ok);
    if (!ok) return 1'b0;
    return ((kk + 1) * n) / m > (kk * n) / m;
  endfunction

  function automatic bit ratio_ok(int n, int m);
    return (m != 0) && (n <= m);
  endfunction

  task automatic chk(bit good, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!good) begin
      errs++;
      $display("FAIL %s %s: act=%0h exp=%0h (k=%0d n=%0d m=%0d)", req, what, act, exp, k, cn, cm);
    end
  endtask

  task automatic step(bit load, int n, int m, int empty_pct);
    bit es;
    buf_empty = ($urandom_range(99) < empty_pct);
    buf_data  = {$urandom, $urandom, $urandom};
    cfg_load  = load;
    if (load) begin
      cfg_num = RW'(n);
      cfg_den = RW'(m);
    end else begin
      cfg_num = RW'($urandom);   // R9: garbage without a load
      cfg_den = RW'($urandom);
    end
    #1;
    es = exp_slot(k, cn, cm, cok);
    chk(slot === es, "R2", "slot", slot, es);
    chk(buf_rd === (es && !buf_empty), "R6", "buf_rd", buf_rd, es && !buf_empty);
    chk(cfg_err === !cok, "R5", "cfg_err", cfg_err, !cok);
    chk(pix_valid === prd, "R7", "pix_valid", pix_valid, prd);
    if (prd) chk(pix_data === pdat, "R7", "pix_data", pix_data, pdat);
    chk(underflow === uf_m, "R8", "underflow", underflow, uf_m);
    if (k < 1024) hist[k] = slot;
    uf_m = uf_m | (es && buf_empty);
    prd  = es && !buf_empty;
    if (prd) pdat = buf_data;
    if (load) begin
      cn = n; cm = m; cok = ratio_ok(n, m); k = 0;
    end else begin
      k++;
    end
    @(negedge clk);
  endtask

  task automatic analyze(int cycles);
    int bad = 0, last = -1, gmin = 1 << 30, gmax = 0, nstr = 0;
    if (!cok || cycles > 1024) return;
    for (int s = 0; s + cm <= cycles; s++) begin
      int c = 0;
      for (int j = 0; j < cm; j++) c += hist[s + j];
      if (c != cn) bad++;
    end
    chk(bad == 0, "R1", "windows with wrong count", bad, 0);
    for (int i = 0; i < cycles; i++) begin
      if (hist[i]) begin
        if (last >= 0) begin
          if (i - last < gmin) gmin = i - last;
          if (i - last > gmax) gmax = i - last;
        end
        last = i;
        nstr++;
      end
    end
    if (nstr >= 3) chk(gmax - gmin <= 1, "R2", "gap spread", gmax - gmin, 1);
  endtask

  task automatic run(int n, int m, int cycles, int empty_pct);
    step(1'b1, n, m, empty_pct);
    for (int i = 0; i < cycles; i++) step(1'b0, 0, 0, empty_pct);
    analyze(cycles);
  endtask

  task automatic do_reset(int n, int m, int cycles);
    rst_n = 1'b0;
    cfg_load = 1'b0;
    cfg_num = RW'(n);
    cfg_den = RW'(m);
    buf_empty = 1'b1;
    repeat (3) @(negedge clk);
    chk(pix_valid === 1'b0, "R10", "pix_valid in reset", pix_valid, 0);
    chk(underflow === 1'b0, "R10", "underflow in reset", underflow, 0);
    chk(pix_data === '0, "R10", "pix_data in reset", pix_data, 0);
    chk(slot === 1'b0, "R10", "slot in reset", slot, 0);
    rst_n = 1'b1;
    cn = n; cm = m; cok = ratio_ok(n, m); k = 0; uf_m = 1'b0; prd = 1'b0;
    for (int i = 0; i < cycles; i++) step(1'b0, 0, 0, 0);
    analyze(cycles);
  endtask

  initial begin
    #1_500_000;
    errs++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset(33, 50, 160);               // R10, R1, R2: the 33 of 50 case
    run(8, 8, 40, 0);                    // R3
    run(0, 20, 60, 0);                   // R4
    run(5, 0, 30, 0);                    // R5: zero period
    run(9, 4, 30, 0);                    // R5: N above M
    run(1, 255, 530, 0);
    run(254, 255, 530, 0);
    run(255, 255, 60, 0);                // R3
    run(3, 7, 80, 50);                   // R8: underflow raised
    chk(underflow === 1'b1, "R8", "underflow raised", underflow, 1);
    run(2, 5, 40, 0);                    // R8: survives load
    chk(underflow === 1'b1, "R8", "underflow kept", underflow, 1);
    do_reset(3, 4, 40);                  // R10: cleared by reset
    for (int r = 0; r < 12; r++) begin
      int m = $urandom_range(255, 1);
      int n = $urandom_range(m, 0);
      run(n, m, 2 * m + 20, $urandom_range(30));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule